// File: doc/BRIEF.md
# Priority Crossbar Request Scheduler

This block decides, once per clock, which inputs of an N-by-N crossbar may send to which outputs. Each input pushes requests into its own short queue. A request names a destination output and one of 16 priority levels, where a smaller number means more urgent. From the queued requests the block builds a set of grants with no conflicts: no output receives two inputs and no input drives two outputs. Each granted request leaves its queue, and every request that is not granted stays queued for later cycles.

Levels are resolved from 0 upward. At each level, every input that has no grant yet offers its oldest queued request of that level whose destination has not already been taken by a more urgent level. Each output then picks one of the inputs that offered to it, using a rotating pointer kept per output. Because outputs taken at earlier levels are skipped when offers are formed, a request stuck behind a contested output does not hold back a less urgent request from the same input that targets a free output. The default is 8 ports; the port count and the queue depth are parameters.

Top module: `xbar_sched`

## Requirements
- R1: While reset is asserted and afterwards with no requests, every `req_rdy` bit is 1 and every `gnt_vld` bit is 0. Every rotating pointer starts at input 0.
- R2: `req_rdy[i]` is 0 exactly when input i's queue holds Q_DEPTH entries. A push offered while `req_rdy[i]` is 0 is discarded and never leads to a grant.
- R3: In any cycle, no two inputs show a grant with the same `gnt_dst` value.
- R4: Each input gets at most one grant per cycle. The grant removes exactly that one entry from its queue, and the remaining entries keep their arrival order.
- R5: When requests of different levels contend for one output, the lowest level number wins. Level 0 beats level 1, and so on up to 15.
- R6: An input whose request loses at some level, or finds its output already taken, can still be granted a less urgent request to a different free output in the same cycle.
- R7: Among inputs offering to the same output at the same level, the winner is the first one found searching upward from that output's pointer, wrapping from N-1 to 0. After a grant, that output's pointer moves to one past the winner.
- R8: At a given level, an input offers only its oldest entry of that level whose destination is still free. The oldest entry is the one pushed earliest.
- R9: A request that is not granted stays queued and competes again in later cycles until it is granted.
- R10: A request pushed at a clock edge takes part in the decision of the next cycle. Its grant shows on `gnt_vld`/`gnt_dst` for one cycle, starting at the edge after the push edge.
- R11: An input offers one entry per level. If that offer loses, the input does not try a different entry of the same level in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | N_PORTS | Per-input push strobe |
| req_dst | input | N_PORTS*DW | Per-input destination output, DW bits each, input i at bits [i*DW +: DW] |
| req_prio | input | N_PORTS*4 | Per-input priority level, 0 most urgent, input i at bits [i*4 +: 4] |
| req_rdy | output | N_PORTS | Per-input queue has room |
| gnt_vld | output | N_PORTS | Per-input grant for this cycle |
| gnt_dst | output | N_PORTS*DW | Per-input granted destination, valid with gnt_vld |

## Verification
The assertions take for granted that each destination value is below N_PORTS. Under that assumption, a grant or a removal always refers to a real output and a live queue slot. They also take for granted that a push is not offered to a full queue and then counted as accepted; the checks on queue fill rely on `req_rdy` gating every push. With 8 ports every 3-bit destination is legal, so the bench keeps within the first assumption by construction. It offers pushes to full queues on purpose, because the second assumption only concerns what the block accepts. Directed sequences set up contention, ties, blocked outputs and queue overflow. A long pseudo-random run mostly uses levels 0 to 3, so that ties and priority collisions occur often.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int unsigned PRIO_LEVELS = 16;
  localparam int unsigned PRIO_W      = $clog2(PRIO_LEVELS);
endpackage

// File: rtl/xs_req_queue.sv
// Per-input request queue: slot 0 is the oldest entry. One entry can be
// removed from any slot per cycle (the rest close up in order) and one
// entry can be appended.
module xs_req_queue
  import xs_pkg::*;
#(
  parameter int unsigned DW    = 3,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_vld,
  input  logic [DW-1:0]            push_dst,
  input  logic [PRIO_W-1:0]        push_prio,
  output logic                     push_rdy,
  input  logic                     pop_en,
  input  logic [SW-1:0]            pop_slot,
  output logic [DEPTH-1:0]         ent_vld,
  output logic [DEPTH*DW-1:0]      ent_dst,
  output logic [DEPTH*PRIO_W-1:0]  ent_prio
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     cnt_q, cnt_d, cnt_kept;
  logic [DW-1:0]     dst_q  [DEPTH];
  logic [DW-1:0]     dst_d  [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [PRIO_W-1:0] prio_d [DEPTH];
  logic              take;
  logic              data_en;

  assign push_rdy = (cnt_q != CW'(DEPTH));
  assign take     = push_vld && push_rdy;
  assign data_en  = take || pop_en;

  // Next state: close the gap left by a removal, then append.
  always_comb begin
    cnt_kept = cnt_q - CW'(pop_en);
    for (int k = 0; k < DEPTH; k++) begin
      dst_d[k]  = dst_q[k];
      prio_d[k] = prio_q[k];
    end
    for (int k = 0; k < DEPTH - 1; k++) begin
      if (pop_en && (SW'(k) >= pop_slot)) begin
        dst_d[k]  = dst_q[k+1];
        prio_d[k] = prio_q[k+1];
      end
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (take && (cnt_kept == CW'(k))) begin
        dst_d[k]  = push_dst;
        prio_d[k] = push_prio;
      end
    end
    cnt_d = cnt_kept + CW'(take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      for (int k = 0; k < DEPTH; k++) begin
        dst_q[k]  <= dst_d[k];
        prio_q[k] <= prio_d[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      ent_vld[k]                   = (CW'(k) < cnt_q);
      ent_dst[k*DW +: DW]          = dst_q[k];
      ent_prio[k*PRIO_W +: PRIO_W] = prio_q[k];
    end
  end

  // R2: occupancy never exceeds the depth
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R2: a full queue does not grow on the next edge
  p_full_no_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !push_rdy |=> cnt_q <= $past(cnt_q));
  // R4: a removal always targets a live slot
  p_pop_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (CW'(pop_slot) < cnt_q));
  // R4: a removal without a push shrinks the queue by exactly one
  p_pop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_vld) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/xs_rr_pick.sv
// Rotating pick: first requester at or above ptr, else lowest requester.
module xs_rr_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic          any
);
  logic [N-1:0] upper, hi_sel, lo_sel;

  always_comb begin
    upper  = req & ({N{1'b1}} << ptr);
    hi_sel = upper & (~upper + N'(1));
    lo_sel = req & (~req + N'(1));
    gnt    = (|upper) ? hi_sel : lo_sel;
    any    = |req;
  end
endmodule

// File: rtl/xs_level_stage.sv
// One priority level: free inputs offer their oldest entry of this level
// whose output is still open; every output picks one offer.
module xs_level_stage
  import xs_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LVL   = 0,
  parameter int unsigned DW    = (N > 1) ? $clog2(N) : 1,
  parameter int unsigned SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [N*DEPTH-1:0]        ent_vld,
  input  logic [N*DEPTH*DW-1:0]     ent_dst,
  input  logic [N*DEPTH*PRIO_W-1:0] ent_prio,
  input  logic [N*DW-1:0]           ptr,
  input  logic [N-1:0]              in_busy_i,
  input  logic [N-1:0]              out_busy_i,
  output logic [N-1:0]              in_busy_o,
  output logic [N-1:0]              out_busy_o,
  output logic [N-1:0]              win,
  output logic [N*SW-1:0]           win_slot,
  output logic [N*DW-1:0]           win_dst
);
  logic [N-1:0]         nom_vld;
  logic [N-1:0][SW-1:0] nom_slot;
  logic [N-1:0][DW-1:0] nom_dst;
  logic [N-1:0][N-1:0]  req_m;
  logic [N-1:0][N-1:0]  gnt_m;
  logic [N-1:0]         took;

  // Offers: scanning down leaves the oldest qualifying slot.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      nom_vld[i]  = 1'b0;
      nom_slot[i] = '0;
      nom_dst[i]  = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
        if (!in_busy_i[i] && ent_vld[i*DEPTH + k] &&
            (ent_prio[(i*DEPTH + k)*PRIO_W +: PRIO_W] == PRIO_W'(LVL)) &&
            !out_busy_i[ent_dst[(i*DEPTH + k)*DW +: DW]]) begin
          nom_vld[i]  = 1'b1;
          nom_slot[i] = SW'(k);
          nom_dst[i]  = ent_dst[(i*DEPTH + k)*DW +: DW];
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        req_m[o][i] = nom_vld[i] && (nom_dst[i] == DW'(o));
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    xs_rr_pick #(.N(N), .IW(DW)) u_pick (
      .req (req_m[o]),
      .ptr (ptr[o*DW +: DW]),
      .gnt (gnt_m[o]),
      .any (took[o])
    );
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      win[i] = 1'b0;
      for (int o = 0; o < N; o++) win[i] = win[i] | gnt_m[o][i];
      win_slot[i*SW +: SW] = nom_slot[i];
      win_dst[i*DW +: DW]  = nom_dst[i];
    end
    in_busy_o  = in_busy_i | win;
    out_busy_o = out_busy_i | took;
  end
endmodule

// File: rtl/xbar_sched.sv
module xbar_sched
  import xs_pkg::*;
#(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned Q_DEPTH = 4,
  parameter int unsigned DW      = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        req_vld,
  input  logic [N_PORTS*DW-1:0]     req_dst,
  input  logic [N_PORTS*PRIO_W-1:0] req_prio,
  output logic [N_PORTS-1:0]        req_rdy,
  output logic [N_PORTS-1:0]        gnt_vld,
  output logic [N_PORTS*DW-1:0]     gnt_dst
);
  localparam int unsigned N  = N_PORTS;
  localparam int unsigned SW = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int unsigned L  = PRIO_LEVELS;

  logic [N*Q_DEPTH-1:0]        ent_vld_all;
  logic [N*Q_DEPTH*DW-1:0]     ent_dst_all;
  logic [N*Q_DEPTH*PRIO_W-1:0] ent_prio_all;
  logic [N-1:0]                pop_en;
  logic [N*SW-1:0]             pop_slot;

  logic [L:0][N-1:0]           in_chain, out_chain;
  logic [L-1:0][N-1:0]         lvl_win;
  logic [L-1:0][N*SW-1:0]      lvl_slot;
  logic [L-1:0][N*DW-1:0]      lvl_dst;

  logic [N-1:0][DW-1:0]        ptr_q, ptr_d;
  logic [N-1:0]                gnt_now;
  logic [N-1:0][DW-1:0]        dst_now;
  logic [N-1:0][SW-1:0]        slot_now;
  logic [N-1:0]                gnt_vld_q;
  logic [N*DW-1:0]             gnt_dst_q;

  for (genvar i = 0; i < N; i++) begin : g_q
    xs_req_queue #(.DW(DW), .DEPTH(Q_DEPTH), .SW(SW)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_vld  (req_vld[i]),
      .push_dst  (req_dst[i*DW +: DW]),
      .push_prio (req_prio[i*PRIO_W +: PRIO_W]),
      .push_rdy  (req_rdy[i]),
      .pop_en    (pop_en[i]),
      .pop_slot  (pop_slot[i*SW +: SW]),
      .ent_vld   (ent_vld_all[i*Q_DEPTH +: Q_DEPTH]),
      .ent_dst   (ent_dst_all[i*Q_DEPTH*DW +: Q_DEPTH*DW]),
      .ent_prio  (ent_prio_all[i*Q_DEPTH*PRIO_W +: Q_DEPTH*PRIO_W])
    );
  end

  assign in_chain[0]  = '0;
  assign out_chain[0] = '0;

  for (genvar l = 0; l < L; l++) begin : g_lvl
    xs_level_stage #(.N(N), .DEPTH(Q_DEPTH), .LVL(l), .DW(DW), .SW(SW)) u_stage (
      .ent_vld    (ent_vld_all),
      .ent_dst    (ent_dst_all),
      .ent_prio   (ent_prio_all),
      .ptr        (ptr_q),
      .in_busy_i  (in_chain[l]),
      .out_busy_i (out_chain[l]),
      .in_busy_o  (in_chain[l+1]),
      .out_busy_o (out_chain[l+1]),
      .win        (lvl_win[l]),
      .win_slot   (lvl_slot[l]),
      .win_dst    (lvl_dst[l])
    );
  end

  // Gather the single grant of each input across levels.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt_now[i]  = 1'b0;
      dst_now[i]  = '0;
      slot_now[i] = '0;
      for (int l = 0; l < L; l++) begin
        if (lvl_win[l][i]) begin
          gnt_now[i]  = 1'b1;
          dst_now[i]  = lvl_dst[l][i*DW +: DW];
          slot_now[i] = lvl_slot[l][i*SW +: SW];
        end
      end
      pop_en[i]            = gnt_now[i];
      pop_slot[i*SW +: SW] = slot_now[i];
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    for (int i = 0; i < N; i++)
      if (gnt_now[i])
        ptr_d[dst_now[i]] = (i == N - 1) ? '0 : DW'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      gnt_vld_q <= '0;
      gnt_dst_q <= '0;
    end else begin
      ptr_q     <= ptr_d;
      gnt_vld_q <= gnt_now;
      gnt_dst_q <= dst_now;
    end
  end

  assign gnt_vld = gnt_vld_q;
  assign gnt_dst = gnt_dst_q;

  // ---------------- assertions ----------------
  logic [N-1:0][N-1:0] out_hit;
  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        out_hit[o][i] = gnt_vld[i] && (gnt_dst[i*DW +: DW] == DW'(o));
  end

  for (genvar o = 0; o < N; o++) begin : g_chk_out
    // R3: one input per output
    p_one_per_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_hit[o]));
  end

  for (genvar i = 0; i < N; i++) begin : g_chk_in
    // R9: a grant only comes from a queue that held an entry
    p_grant_from_queue_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[i] |-> $past(ent_vld_all[i*Q_DEPTH]));
    // R7: the granted output's pointer sits one past the winner
    p_ptr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_vld[i] |-> ptr_q[gnt_dst[i*DW +: DW]] == ((i == N - 1) ? DW'(0) : DW'(i + 1)));
  end
endmodule

// File: tb/sim_xbar_sched.sv
module sim_xbar_sched;
  localparam int N  = 8;
  localparam int Q  = 4;
  localparam int DW = 3;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    req_vld;
  logic [N*DW-1:0] req_dst;
  logic [N*PW-1:0] req_prio;
  logic [N-1:0]    req_rdy;
  logic [N-1:0]    gnt_vld;
  logic [N*DW-1:0] gnt_dst;

  logic          drv_v [N];
  logic [DW-1:0] drv_d [N];
  logic [PW-1:0] drv_p [N];

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_vld[i]           = drv_v[i];
      req_dst[i*DW +: DW]  = drv_d[i];
      req_prio[i*PW +: PW] = drv_p[i];
    end
  end

  xbar_sched #(.N_PORTS(N), .Q_DEPTH(Q)) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dst(req_dst),
    .req_prio(req_prio), .req_rdy(req_rdy), .gnt_vld(gnt_vld), .gnt_dst(gnt_dst)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference state
  int mq_cnt [N];
  int mq_dst [N][Q];
  int mq_pri [N][Q];
  int mptr   [N];
  int exp_gv [N];
  int exp_gd [N];
  int lfsr = 32'h1234_5678;

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    for (int i = 0; i < N; i++) begin
      drv_v[i] = 1'b0; drv_d[i] = '0; drv_p[i] = '0;
    end
  endtask

  task automatic set_req(int i, int p, int d);
    drv_v[i] = 1'b1; drv_p[i] = PW'(p); drv_d[i] = DW'(d);
  endtask

  // Decision from the requirements: levels ascending, oldest free offer per
  // input, rotating pick per output, then removal and append.
  task automatic model_cycle();
    bit inb [N];
    bit outb [N];
    int gslot [N];
    int gdst [N];
    int nom [N];
    int nd [N];
    bit acc [N];
    for (int i = 0; i < N; i++) begin
      inb[i] = 0; outb[i] = 0; gslot[i] = -1; gdst[i] = 0;
      acc[i] = drv_v[i] && (mq_cnt[i] < Q);
    end
    for (int l = 0; l < 16; l++) begin
      for (int i = 0; i < N; i++) begin
        nom[i] = -1; nd[i] = 0;
        if (!inb[i]) begin
          for (int k = 0; k < mq_cnt[i]; k++) begin
            if (nom[i] < 0 && mq_pri[i][k] == l && !outb[mq_dst[i][k]]) begin
              nom[i] = k; nd[i] = mq_dst[i][k];
            end
          end
        end
      end
      for (int o = 0; o < N; o++) begin
        int w;
        w = -1;
        for (int t = 0; t < N; t++) begin
          int c;
          c = (mptr[o] + t) % N;
          if (w < 0 && nom[c] >= 0 && nd[c] == o) w = c;
        end
        if (w >= 0) begin
          outb[o] = 1; inb[w] = 1; gslot[w] = nom[w]; gdst[w] = o;
          mptr[o] = (w + 1) % N;
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      if (gslot[i] >= 0) begin
        for (int k = gslot[i]; k < Q - 1; k++) begin
          mq_dst[i][k] = mq_dst[i][k+1]; mq_pri[i][k] = mq_pri[i][k+1];
        end
        mq_cnt[i]--;
      end
      if (acc[i]) begin
        mq_dst[i][mq_cnt[i]] = int'(drv_d[i]);
        mq_pri[i][mq_cnt[i]] = int'(drv_p[i]);
        mq_cnt[i]++;
      end
      exp_gv[i] = (gslot[i] >= 0) ? 1 : 0;
      exp_gd[i] = gdst[i];
    end
  endtask

  // Called at a falling edge: check outputs, predict, cross one rising edge.
  task automatic step(string tag);
    for (int i = 0; i < N; i++) begin
      chk(tag, $sformatf("gnt_vld[%0d]", i), int'(gnt_vld[i]), exp_gv[i]);
      if (exp_gv[i] != 0)
        chk(tag, $sformatf("gnt_dst[%0d]", i), int'(gnt_dst[i*DW +: DW]), exp_gd[i]);
      chk("R2", $sformatf("req_rdy[%0d]", i), int'(req_rdy[i]), (mq_cnt[i] < Q) ? 1 : 0);
    end
    for (int o = 0; o < N; o++) begin
      int hits;
      hits = 0;
      for (int i = 0; i < N; i++)
        if (gnt_vld[i] && int'(gnt_dst[i*DW +: DW]) == o) hits++;
      chk("R3", $sformatf("grants to output %0d", o), (hits > 1) ? hits : 0, 0);
    end
    model_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain(string tag, int cycles);
    idle_inputs();
    for (int c = 0; c < cycles; c++) step(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    for (int i = 0; i < N; i++) begin
      mq_cnt[i] = 0; mptr[i] = 0; exp_gv[i] = 0; exp_gd[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "req_rdy in reset", int'(req_rdy), 8'hFF);
    chk("R1", "gnt_vld in reset", int'(gnt_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "gnt_vld after reset", int'(gnt_vld), 0);

    // R10: push edge, then decision, grant one edge later
    set_req(7, 9, 7);
    step("R10");
    chk("R10", "no grant right after push edge", int'(gnt_vld), 0);
    idle_inputs();
    step("R10");
    chk("R10", "grant input 7 one edge later", int'(gnt_vld[7]), 1);
    chk("R10", "grant dst input 7", int'(gnt_dst[7*DW +: DW]), 7);
    step("R10");
    chk("R10", "grant lasts one cycle", int'(gnt_vld[7]), 0);

    // R5 / R9: urgent level beats earlier-pointer input; loser stays queued
    set_req(2, 7, 0); set_req(5, 1, 0);
    step("R5");
    idle_inputs();
    step("R5");
    chk("R5", "level 1 wins output 0", int'(gnt_vld[5]), 1);
    chk("R5", "level 7 loses output 0", int'(gnt_vld[2]), 0);
    step("R9");
    chk("R9", "retained request granted later", int'(gnt_vld[2]), 1);

    // R6: contested urgent entry does not block a free output
    idle_inputs(); set_req(0, 0, 5); set_req(4, 1, 5);
    step("R6");
    idle_inputs(); set_req(0, 0, 5); set_req(4, 2, 6);
    step("R6");
    idle_inputs();
    step("R6");
    chk("R6", "input 0 holds output 5", int'(gnt_dst[0*DW +: DW]), 5);
    chk("R6", "input 4 level-2 grant", int'(gnt_vld[4]), 1);
    chk("R6", "input 4 goes to output 6", int'(gnt_dst[4*DW +: DW]), 6);
    drain("R6", 3);

    // R8: oldest free entry of a level is offered first
    set_req(0, 0, 3); set_req(6, 2, 3);
    step("R8");
    idle_inputs(); set_req(6, 2, 4);
    step("R8");
    idle_inputs();
    step("R8");
    chk("R8", "input 6 granted", int'(gnt_vld[6]), 1);
    chk("R8", "oldest entry chosen", int'(gnt_dst[6*DW +: DW]), 3);
    drain("R8", 3);

    // R2: fill input 1 behind a stream on output 2, then overflow it
    for (int c = 0; c < 6; c++) begin
      idle_inputs(); set_req(0, 0, 2); set_req(1, 15, 2);
      step("R2");
      if (c == 3) chk("R2", "ready low when full", int'(req_rdy[1]), 0);
    end
    begin
      int got;
      got = 0;
      idle_inputs();
      for (int c = 0; c < 8; c++) begin
        step("R9");
        if (gnt_vld[1]) got++;
      end
      chk("R2", "only four entries granted after overflow", got, 4);
    end

    // R7: three inputs share output 1 at one level
    for (int c = 0; c < 9; c++) begin
      idle_inputs(); set_req(2, 3, 1); set_req(5, 3, 1); set_req(7, 3, 1);
      step("R7");
    end
    drain("R7", 14);

    // R11/R4: pseudo-random sweep, mostly levels 0..3
    for (int c = 0; c < 3000; c++) begin
      idle_inputs();
      for (int i = 0; i < N; i++) begin
        lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
        if (lfsr[0] || lfsr[9])
          set_req(i, lfsr[12] ? int'(lfsr[7:4]) : int'(lfsr[5:4]), int'(lfsr[3:1]));
      end
      step((c % 2 == 0) ? "R11" : "R4");
    end
    drain("R9", 20);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule